// File: doc/BRIEF.md
# TLB Access Protection Checker

This block decides what happens to a memory access once the translation lookaside buffer has found a matching entry. The matched entry's attributes arrive on the block's inputs: a protection group number, a two-bit page protection code, a change bit, and the cache-inhibit, writethrough and guarded flags. The access itself is described by its type, the privilege level, a speculative flag and a cancel input. From these the block either grants the access, holds it in a stall, or raises exactly one fault. A write to an unmodified page also pulses an invalidate strobe for the matched entry.

The protection group number selects a two-bit field from a sixteen-field group protection register, which software loads through a write-enable and data port. A mode input sets how the field is read. In segment-key mode the field supplies protection keys. In domain mode it supplies an override of the page protection. When translation is off for the access, every check is skipped and the access is granted. Decisions are combinational from the current inputs. The only state is the group protection register and its reset synchronizer.

Top module: `tlb_prot_check`

## Requirements
- R1: After reset every group field reads 00. Field g occupies bits [2g+1:2g] of `grp_wdata`. It loads on the clock edge where `grp_we` is high and holds its value otherwise.
- R2: In segment-key mode (`dom_mode`=0), field bit 1 is the supervisor key and bit 0 is the user key. The key used is the user key when `user`=1 and the supervisor key otherwise. The permission for each page code is: 00 gives none if the key is 1 and read/write if it is 0; 01 gives read-only if the key is 1 and read/write if it is 0; 10 gives read/write; 11 gives read-only.
- R3: In domain mode (`dom_mode`=1), field 00 denies all access and field 11 allows read/write. Fields 01 and 10 apply the page code table of R2, with the key equal to `user`.
- R4: Access type encoding is 00 fetch, 01 read, 10 write, 11 read. A fetch or read needs read permission and a write needs write permission. A denied fetch raises `inst_fault`; a denied data access raises `data_fault`.
- R5: A permitted fetch from a guarded page raises `inst_fault` and is not granted.
- R6: A permitted write to a page whose change bit is 0 raises `dtlb_err` and `inval` in the same cycle, with no grant.
- R7: A permitted data access to a guarded page while `spec`=1 holds `stall` with `grant` low. Once `spec` falls, the access is granted.
- R8: When `cancel`=1, all outputs are low.
- R9: Faults are checked in the order denial, guarded fetch, change-bit write. At most one fault output is high at a time. `grant` is low whenever any fault or `stall` is high.
- R10: With `xlat_en`=0, a valid uncancelled access gets `grant`=1. No fault or stall is raised, and `eff_ci` and `eff_wt` are 0.
- R11: On a translated grant, `eff_ci` = `pg_ci` OR `pg_coh` and `eff_wt` = `pg_wt`. Both are 0 without a grant.
- R12: With `acc_vld`=0, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_we | input | 1 | Group protection register write enable |
| grp_wdata | input | 32 | Group protection register write data, two bits per group |
| dom_mode | input | 1 | 0 = segment-key mode, 1 = domain mode |
| xlat_en | input | 1 | Translation enabled for this access |
| acc_vld | input | 1 | Access present |
| acc_type | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| user | input | 1 | 1 = user privilege, 0 = supervisor |
| spec | input | 1 | Access is speculative |
| cancel | input | 1 | Core cancels the access |
| pg_grp | input | 4 | Protection group number of the matched entry |
| pg_pp | input | 2 | Page protection code |
| pg_chg | input | 1 | Change bit (0 = page unmodified) |
| pg_ci | input | 1 | Cache-inhibit attribute |
| pg_wt | input | 1 | Writethrough attribute |
| pg_grd | input | 1 | Guarded attribute |
| pg_coh | input | 1 | Page needs coherence |
| grant | output | 1 | Access may proceed |
| stall | output | 1 | Access held |
| inst_fault | output | 1 | Instruction storage fault |
| data_fault | output | 1 | Data protection fault |
| dtlb_err | output | 1 | Data TLB error |
| inval | output | 1 | Invalidate the matched entry |
| eff_ci | output | 1 | Effective cache-inhibit for a granted access |
| eff_wt | output | 1 | Effective writethrough for a granted access |

## Verification
Several properties are checked on every cycle: at most one fault is high, grant never coincides with a fault or stall, cancel silences all outputs, a guarded fetch always faults, `inval` always comes with `dtlb_err`, an untranslated access is granted, and the register holds without a write enable. Only the bench scenarios can show the permission tables of both modes, the field placement in the write data, and the exact priority when several conditions meet. The same is true of the stall releasing into a grant when `spec` drops, and of attribute forwarding. These are compared against a bench model over directed and random accesses.

// File: rtl/tlbprot_pkg.sv
package tlbprot_pkg;
  localparam int unsigned FLD_W = 2;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    DOM_DENY = 2'b00,
    DOM_PAGE = 2'b01,
    DOM_RSVD = 2'b10,
    DOM_FREE = 2'b11
  } dom_e;

  typedef struct packed {
    logic rd;
    logic wr;
  } perm_t;

  function automatic perm_t page_perm(input logic [1:0] pp, input logic key);
    perm_t p;
    case (pp)
      2'b00:   p = key ? '{rd: 1'b0, wr: 1'b0} : '{rd: 1'b1, wr: 1'b1};
      2'b01:   p = key ? '{rd: 1'b1, wr: 1'b0} : '{rd: 1'b1, wr: 1'b1};
      2'b10:   p = '{rd: 1'b1, wr: 1'b1};
      default: p = '{rd: 1'b1, wr: 1'b0};
    endcase
    return p;
  endfunction
endpackage

// File: rtl/prot_grp_reg.sv
module prot_grp_reg
  import tlbprot_pkg::*;
#(
  parameter int unsigned NUM_GRP = 16,
  localparam int unsigned GRP_W  = $clog2(NUM_GRP),
  localparam int unsigned REG_W  = NUM_GRP * FLD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic [GRP_W-1:0] grp,
  output logic [FLD_W-1:0] fld
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [REG_W-1:0] grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_fld
    logic [FLD_W-1:0] fld_d;
    always_comb begin
      fld_d = grp_q[g*FLD_W +: FLD_W];
      if (we) fld_d = wdata[g*FLD_W +: FLD_W];
    end
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) grp_q[g*FLD_W +: FLD_W] <= '0;
      else            grp_q[g*FLD_W +: FLD_W] <= fld_d;
    end
  end

  assign fld = grp_q[grp*FLD_W +: FLD_W];

  AST_GRP_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !we |=> $stable(grp_q)) else $error("group register changed without write"); // R1
  AST_GRP_LOAD: assert property (@(posedge clk) disable iff (!rst_int_n)
    we |=> grp_q == $past(wdata)) else $error("group register missed write"); // R1
endmodule

// File: rtl/perm_decode.sv
module perm_decode
  import tlbprot_pkg::*;
(
  input  logic             dom_mode,
  input  logic [FLD_W-1:0] fld,
  input  logic             user,
  input  logic [1:0]       pp,
  output perm_t            perm
);
  logic seg_key;

  always_comb begin
    seg_key = user ? fld[0] : fld[1];
    if (!dom_mode) begin
      perm = page_perm(pp, seg_key);
    end else begin
      case (dom_e'(fld))
        DOM_DENY: perm = '{rd: 1'b0, wr: 1'b0};
        DOM_FREE: perm = '{rd: 1'b1, wr: 1'b1};
        default:  perm = page_perm(pp, user);
      endcase
    end
  end
endmodule

// File: rtl/access_ctrl.sv
module access_ctrl
  import tlbprot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xlat_en,
  input  logic       acc_vld,
  input  logic [1:0] acc_type,
  input  logic       spec,
  input  logic       cancel,
  input  perm_t      perm,
  input  logic       pg_chg,
  input  logic       pg_ci,
  input  logic       pg_wt,
  input  logic       pg_grd,
  input  logic       pg_coh,
  output logic       grant,
  output logic       stall,
  output logic       inst_fault,
  output logic       data_fault,
  output logic       dtlb_err,
  output logic       inval,
  output logic       eff_ci,
  output logic       eff_wt
);
  logic is_fetch;
  logic is_write;
  logic allowed;

  always_comb begin
    is_fetch   = acc_e'(acc_type) == ACC_FETCH;
    is_write   = acc_e'(acc_type) == ACC_WRITE;
    allowed    = is_write ? perm.wr : perm.rd;
    grant      = 1'b0;
    stall      = 1'b0;
    inst_fault = 1'b0;
    data_fault = 1'b0;
    dtlb_err   = 1'b0;
    inval      = 1'b0;
    eff_ci     = 1'b0;
    eff_wt     = 1'b0;
    if (acc_vld && !cancel) begin
      if (!xlat_en) begin
        grant = 1'b1;
      end else if (!allowed) begin
        if (is_fetch) inst_fault = 1'b1;
        else          data_fault = 1'b1;
      end else if (is_fetch && pg_grd) begin
        inst_fault = 1'b1;
      end else if (is_write && !pg_chg) begin
        dtlb_err = 1'b1;
        inval    = 1'b1;
      end else if (!is_fetch && pg_grd && spec) begin
        stall = 1'b1;
      end else begin
        grant  = 1'b1;
        eff_ci = pg_ci | pg_coh;
        eff_wt = pg_wt;
      end
    end
  end

  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({inst_fault, data_fault, dtlb_err}) <= 1) else $error("several faults"); // R9
  AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !(stall || inst_fault || data_fault || dtlb_err)) else $error("grant with fault"); // R9
  AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |-> !(grant || stall || inst_fault || data_fault || dtlb_err || inval)) else $error("cancel ignored"); // R8
  AST_GRD_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !cancel && xlat_en && is_fetch && pg_grd) |-> inst_fault) else $error("guarded fetch ran"); // R5
  AST_INVAL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    inval |-> dtlb_err) else $error("invalidate without error"); // R6
  AST_XLAT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !cancel && !xlat_en) |-> (grant && !eff_ci && !eff_wt)) else $error("untranslated not granted"); // R10
endmodule

// File: rtl/tlb_prot_check.sv
module tlb_prot_check
  import tlbprot_pkg::*;
#(
  parameter int unsigned NUM_GRP = 16,
  localparam int unsigned GRP_W  = $clog2(NUM_GRP),
  localparam int unsigned REG_W  = NUM_GRP * FLD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_we,
  input  logic [REG_W-1:0] grp_wdata,
  input  logic             dom_mode,
  input  logic             xlat_en,
  input  logic             acc_vld,
  input  logic [1:0]       acc_type,
  input  logic             user,
  input  logic             spec,
  input  logic             cancel,
  input  logic [GRP_W-1:0] pg_grp,
  input  logic [1:0]       pg_pp,
  input  logic             pg_chg,
  input  logic             pg_ci,
  input  logic             pg_wt,
  input  logic             pg_grd,
  input  logic             pg_coh,
  output logic             grant,
  output logic             stall,
  output logic             inst_fault,
  output logic             data_fault,
  output logic             dtlb_err,
  output logic             inval,
  output logic             eff_ci,
  output logic             eff_wt
);
  logic [FLD_W-1:0] sel_fld;
  perm_t            perm;

  prot_grp_reg #(.NUM_GRP(NUM_GRP)) u_grp_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (grp_we),
    .wdata (grp_wdata),
    .grp   (pg_grp),
    .fld   (sel_fld)
  );

  perm_decode u_perm (
    .dom_mode (dom_mode),
    .fld      (sel_fld),
    .user     (user),
    .pp       (pg_pp),
    .perm     (perm)
  );

  access_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .xlat_en    (xlat_en),
    .acc_vld    (acc_vld),
    .acc_type   (acc_type),
    .spec       (spec),
    .cancel     (cancel),
    .perm       (perm),
    .pg_chg     (pg_chg),
    .pg_ci      (pg_ci),
    .pg_wt      (pg_wt),
    .pg_grd     (pg_grd),
    .pg_coh     (pg_coh),
    .grant      (grant),
    .stall      (stall),
    .inst_fault (inst_fault),
    .data_fault (data_fault),
    .dtlb_err   (dtlb_err),
    .inval      (inval),
    .eff_ci     (eff_ci),
    .eff_wt     (eff_wt)
  );

  AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |-> !(grant || stall || inst_fault || data_fault || dtlb_err || inval || eff_ci || eff_wt))
    else $error("outputs without access"); // R12
endmodule

// File: tb/test_tlb_prot_check.sv
module test_tlb_prot_check;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        grp_we;
  logic [31:0] grp_wdata;
  logic        dom_mode, xlat_en, acc_vld, user, spec, cancel;
  logic [1:0]  acc_type, pg_pp;
  logic [3:0]  pg_grp;
  logic        pg_chg, pg_ci, pg_wt, pg_grd, pg_coh;
  logic        grant, stall, inst_fault, data_fault, dtlb_err, inval, eff_ci, eff_wt;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] grp_model;

  always #2.5 clk = ~clk;

  tlb_prot_check i_tlb_prot_check (.*);

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // expected {grant,stall,inst_fault,data_fault,dtlb_err,inval,eff_ci,eff_wt}
  function automatic logic [7:0] expect_out();
    logic [1:0] f;
    logic k, rd, wr, ok, fetch, wrt;
    logic [7:0] r;
    r = 8'h00;
    f = grp_model[pg_grp*2 +: 2];
    fetch = acc_type == 2'b00;
    wrt   = acc_type == 2'b10;
    if (!dom_mode) k = user ? f[0] : f[1];
    else           k = user;
    case (pg_pp)
      2'b00: begin rd = !k; wr = !k; end
      2'b01: begin rd = 1'b1; wr = !k; end
      2'b10: begin rd = 1'b1; wr = 1'b1; end
      default: begin rd = 1'b1; wr = 1'b0; end
    endcase
    if (dom_mode && f == 2'b00) begin rd = 1'b0; wr = 1'b0; end
    if (dom_mode && f == 2'b11) begin rd = 1'b1; wr = 1'b1; end
    ok = wrt ? wr : rd;
    if (!acc_vld || cancel)          r = 8'h00;
    else if (!xlat_en)               r = 8'b1000_0000;
    else if (!ok)                    r = fetch ? 8'b0010_0000 : 8'b0001_0000;
    else if (fetch && pg_grd)        r = 8'b0010_0000;
    else if (wrt && !pg_chg)         r = 8'b0000_1100;
    else if (!fetch && pg_grd && spec) r = 8'b0100_0000;
    else r = {6'b100000, pg_ci | pg_coh, pg_wt};
    return r;
  endfunction

  task automatic check(input string tag);
    logic [7:0] act, exp;
    #1;
    act = {grant, stall, inst_fault, data_fault, dtlb_err, inval, eff_ci, eff_wt};
    exp = expect_out();
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic write_grp(input logic [31:0] d);
    @(negedge clk);
    grp_we = 1'b1; grp_wdata = d;
    @(posedge clk);
    grp_model = d;
    @(negedge clk);
    grp_we = 1'b0;
  endtask

  task automatic set_acc(input logic [1:0] t, input logic u, input logic [3:0] g,
                         input logic [1:0] pp, input logic chg, input logic grd, input logic sp);
    @(negedge clk);
    acc_vld = 1'b1; acc_type = t; user = u; pg_grp = g; pg_pp = pp;
    pg_chg = chg; pg_grd = grd; spec = sp; cancel = 1'b0; xlat_en = 1'b1;
    pg_ci = 1'b0; pg_wt = 1'b0; pg_coh = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; grp_we = 1'b0; grp_wdata = '0; dom_mode = 1'b0; xlat_en = 1'b1;
    acc_vld = 1'b0; acc_type = 2'b01; user = 1'b0; spec = 1'b0; cancel = 1'b0;
    pg_grp = '0; pg_pp = 2'b00; pg_chg = 1'b1; pg_ci = 1'b0; pg_wt = 1'b0;
    pg_grd = 1'b0; pg_coh = 1'b0; grp_model = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 idle after reset");
    // R1: zero fields give key 0, so pp00 write is allowed
    set_acc(2'b10, 1'b1, 4'd9, 2'b00, 1'b1, 1'b0, 1'b0); check("R1 reset field zero");
    // R1: group 5 = 10 (supervisor key 1, user key 0), group 6 = 00, group 7 = 11
    write_grp(32'h0000_C800);
    set_acc(2'b01, 1'b0, 4'd5, 2'b00, 1'b1, 1'b0, 1'b0); check("R1 field placement grp5");
    set_acc(2'b01, 1'b0, 4'd4, 2'b00, 1'b1, 1'b0, 1'b0); check("R1 neighbour grp4");
    // R2: segment-key table
    set_acc(2'b10, 1'b1, 4'd5, 2'b00, 1'b1, 1'b0, 1'b0); check("R2 user key0 pp00 write");
    set_acc(2'b10, 1'b0, 4'd5, 2'b01, 1'b1, 1'b0, 1'b0); check("R2 sup key1 pp01 write");
    set_acc(2'b01, 1'b0, 4'd5, 2'b01, 1'b1, 1'b0, 1'b0); check("R2 sup key1 pp01 read");
    set_acc(2'b10, 1'b0, 4'd5, 2'b11, 1'b1, 1'b0, 1'b0); check("R2 pp11 write");
    set_acc(2'b10, 1'b0, 4'd5, 2'b10, 1'b1, 1'b0, 1'b0); check("R2 pp10 write");
    // R3: domain mode
    dom_mode = 1'b1;
    set_acc(2'b01, 1'b0, 4'd6, 2'b10, 1'b1, 1'b0, 1'b0); check("R3 deny field");
    set_acc(2'b10, 1'b1, 4'd7, 2'b11, 1'b1, 1'b0, 1'b0); check("R3 free field");
    set_acc(2'b11, 1'b1, 4'd5, 2'b00, 1'b1, 1'b0, 1'b0); check("R3 reserved field uses page");
    dom_mode = 1'b0;
    // R4: denied fetch
    set_acc(2'b00, 1'b0, 4'd5, 2'b00, 1'b1, 1'b0, 1'b0); check("R4 denied fetch");
    // R5: guarded fetch
    set_acc(2'b00, 1'b0, 4'd1, 2'b10, 1'b1, 1'b1, 1'b0); check("R5 guarded fetch");
    // R6: unmodified page write
    set_acc(2'b10, 1'b0, 4'd1, 2'b10, 1'b0, 1'b0, 1'b0); check("R6 change bit write");
    // R9: priority
    set_acc(2'b10, 1'b0, 4'd5, 2'b11, 1'b0, 1'b1, 1'b1); check("R9 denial before change bit");
    set_acc(2'b00, 1'b0, 4'd5, 2'b00, 1'b1, 1'b1, 1'b0); check("R9 denial before guarded fetch");
    // R7: stall until nonspeculative
    set_acc(2'b01, 1'b0, 4'd1, 2'b10, 1'b1, 1'b1, 1'b1); check("R7 stall");
    @(negedge clk); check("R7 stall held");
    @(negedge clk); spec = 1'b0; check("R7 released");
    // R8: cancel during stall
    set_acc(2'b10, 1'b0, 4'd1, 2'b10, 1'b1, 1'b1, 1'b1); check("R7 write stall");
    @(negedge clk); cancel = 1'b1; check("R8 cancel");
    // R10: translation off
    set_acc(2'b00, 1'b0, 4'd5, 2'b00, 1'b0, 1'b1, 1'b0);
    xlat_en = 1'b0; pg_ci = 1'b1; pg_wt = 1'b1; check("R10 untranslated");
    // R11: attributes
    set_acc(2'b01, 1'b0, 4'd1, 2'b10, 1'b1, 1'b0, 1'b0);
    pg_coh = 1'b1; pg_wt = 1'b1; check("R11 coherent forces inhibit");
    set_acc(2'b01, 1'b0, 4'd1, 2'b10, 1'b1, 1'b0, 1'b0);
    pg_ci = 1'b1; check("R11 inhibit passes");
    // R12: no access
    @(negedge clk); acc_vld = 1'b0; check("R12 idle");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) write_grp($urandom());
      @(negedge clk);
      dom_mode = 1'($urandom()); xlat_en = ($urandom_range(0, 7) != 0);
      acc_vld = ($urandom_range(0, 7) != 0); acc_type = 2'($urandom());
      user = 1'($urandom()); spec = 1'($urandom()); cancel = ($urandom_range(0, 9) == 0);
      pg_grp = 4'($urandom()); pg_pp = 2'($urandom()); pg_chg = 1'($urandom());
      pg_ci = 1'($urandom()); pg_wt = 1'($urandom()); pg_grd = 1'($urandom());
      pg_coh = 1'($urandom());
      check("R9 random R2 R3 R4 mix");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule